// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a word-wide memory port. It holds recently used data in lines of eight 32-bit words, with one line slot for each index. Stores stay in the cache and mark their line dirty. A dirty line goes back to memory only when a miss replaces it or when a maintenance operation asks for it. A store miss first brings the line in and then merges the store into it. The capacity is set by the parameter `CACHE_KB`, which may be 1, 2, 4, 8 or 16. The index is therefore 5 to 9 bits wide, the tag takes the remaining high bits, and the byte offset is always 5 bits.

The processor presents one request at a time on `cpu_req`, together with `cpu_op`, `cpu_addr`, `cpu_wdata` and `cpu_be`. It holds all of these stable until `cpu_ready` is high, and the request completes at that clock edge. Besides reads and writes, the cache runs three maintenance operations: clean, flush and invalidate. Each operation comes in two forms. The address form checks the tag and does nothing on a miss. The index form selects the line slot directly and ignores its tag.

On the memory side, the cache issues one word request per cycle. A request stays on the port until `mem_gnt` accepts it. Read data comes back in request order on `mem_rvalid`.

Top module: `dcache_wb`

## Requirements
- R1: After reset the cache visits every index once to clear its valid and dirty state. During this sweep, which lasts one cycle per line, `cpu_ready` and `mem_req` both stay low.
- R2: A read (`cpu_op`=0) that hits completes with `cpu_ready` in the first cycle it is presented. `cpu_rdata` then carries the word, and no memory request is made.
- R3: A write (`cpu_op`=1) that hits updates only the bytes whose `cpu_be` bit is set (bit n selects bits 8n+7:8n). It completes in the first cycle and makes no memory request.
- R4: A miss to a line that is invalid or clean issues eight reads, words 0 to 7 of the line in ascending address order. The port holds an ungranted request stable, and moves to the next word the cycle after a grant. Addresses are word aligned.
- R5: A miss whose line slot holds a valid dirty line first writes that line's eight words back, in ascending order, at the address built from the stored tag and index. Only then does it fetch the new line. `cpu_ready` stays low while memory traffic is in progress.
- R6: A write miss fetches the line and then merges the store data, without writing anything to memory.
- R7: Clean by address (`cpu_op`=2) on a dirty hit writes the line back and leaves it valid and clean. A later read hits with no traffic, and a later eviction writes nothing.
- R8: Flush by address (`cpu_op`=3) on a hit writes the line back if it is dirty and then invalidates it, so the next read refetches it.
- R9: Invalidate (`cpu_op`=4 by address, 7 by index) drops the line without writing it back, so unsaved store data is lost.
- R10: An address-form operation (`cpu_op` 2, 3 or 4) whose tag does not match, or whose line is invalid, completes in the first cycle. It makes no memory request and leaves the line's contents and state unchanged.
- R11: The index forms (`cpu_op`=5 clean, 6 flush, 7 invalidate) take the line index from `cpu_addr[IW-1:0]` and ignore all higher address bits. They act on a valid line whatever its tag is, with the same effect as the matching address form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request present |
| cpu_op | input | 3 | 0 read, 1 write, 2/3/4 clean/flush/invalidate by address, 5/6/7 by index |
| cpu_addr | input | 32 | Byte address, or line index in the low bits for index forms |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 write-back word, 0 fill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read word |

## Verification
The hardest cases to reach are the ones where the line slot already holds a line of a different tag in a particular state. Examples are an address-form operation that must miss on a valid dirty line, or an index-form operation on a line that has just been cleaned. The bench builds each state explicitly with a chain of accesses to addresses that share an index but differ in tag. It then checks the result at the memory port: how many reads and write-backs occur, in what order, and at which addresses. A read afterwards shows whether the line stayed valid and which data it holds. The memory model withholds the grant in every third cycle, so the bursts cross held requests.

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int CACHE_KB = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic [2:0]  cpu_op,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic [3:0]  cpu_be,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int LINES = CACHE_KB * 32;
  localparam int IW    = $clog2(LINES);
  localparam int TW    = 32 - 5 - IW;
  localparam int WORDS = LINES * 8;

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_WB, ST_FILL} st_t;

  st_t              st;
  logic [LINES-1:0] vld, drt;
  logic [TW-1:0]    tags  [LINES];
  logic [31:0]      words [WORDS];
  logic [IW-1:0]    sweep;
  logic [3:0]       issued;
  logic [2:0]       got;

  wire          by_idx   = cpu_op[2] & (cpu_op[1] | cpu_op[0]);
  wire [IW-1:0] idx      = by_idx ? cpu_addr[IW-1:0] : cpu_addr[5 +: IW];
  wire [TW-1:0] req_tag  = cpu_addr[31 -: TW];
  wire          line_hit = vld[idx] && (tags[idx] == req_tag);
  wire          target   = by_idx ? vld[idx] : line_hit;
  wire          is_rw    = (cpu_op[2:1] == 2'b00);
  wire          is_inval = (cpu_op == 3'd4) || (cpu_op == 3'd7);
  wire          is_flush = (cpu_op == 3'd3) || (cpu_op == 3'd6);
  wire          victim   = vld[idx] && drt[idx];
  wire          need_wb  = is_rw ? (!line_hit && victim) : (!is_inval && target && drt[idx]);
  wire          need_fill = is_rw && !line_hit && !victim;
  wire          done     = cpu_req && (st == ST_IDLE) && !need_wb && !need_fill;
  wire          wb_last  = (st == ST_WB) && mem_gnt && (issued == 4'd7);

  assign cpu_ready = done;
  assign cpu_rdata = words[{idx, cpu_addr[4:2]}];
  assign mem_req   = ((st == ST_WB) || (st == ST_FILL)) && !issued[3];
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = {(st == ST_WB) ? tags[idx] : req_tag, idx, issued[2:0], 2'b00};
  assign mem_wdata = words[{idx, issued[2:0]}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_INIT;
      sweep  <= '0;
      issued <= '0;
      got    <= '0;
    end else begin
      case (st)
        ST_INIT: begin
          sweep <= sweep + 1'b1;
          if (&sweep) st <= ST_IDLE;
        end
        ST_IDLE: begin
          issued <= '0;
          got    <= '0;
          if (cpu_req && need_wb)        st <= ST_WB;
          else if (cpu_req && need_fill) st <= ST_FILL;
        end
        ST_WB: begin
          if (mem_req && mem_gnt) issued <= issued + 4'd1;
          if (wb_last) st <= ST_IDLE;
        end
        default: begin
          if (mem_req && mem_gnt) issued <= issued + 4'd1;
          if (mem_rvalid) begin
            got <= got + 3'd1;
            if (got == 3'd7) st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_INIT) begin
      vld[sweep] <= 1'b0;
      drt[sweep] <= 1'b0;
    end
    if (wb_last) drt[idx] <= 1'b0;
    if (st == ST_FILL && mem_rvalid) begin
      words[{idx, got}] <= mem_rdata;
      if (got == 3'd7) begin
        vld[idx]  <= 1'b1;
        tags[idx] <= req_tag;
      end
    end
    if (done && cpu_op == 3'd1) begin
      drt[idx] <= 1'b1;
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) words[{idx, cpu_addr[4:2]}][8*b +: 8] <= cpu_wdata[8*b +: 8];
    end
    if (done && target && (is_flush || is_inval)) begin
      vld[idx] <= 1'b0;
      drt[idx] <= 1'b0;
    end
  end
endmodule

module dcache_wb_chk #(
  parameter int LINES = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic [2:0]  cpu_op,
  input logic        cpu_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr
);
  localparam int AW = $clog2(LINES) + 1;
  localparam logic [AW-1:0] LIM = AW'(LINES);

  logic [AW-1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age < LIM) age <= age + 1'b1;

  assert_sweep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age < LIM) |-> (!cpu_ready && !mem_req));

  assert_hold_ungranted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_addr[4:2] != 3'd7) |=> (mem_req && mem_addr == $past(mem_addr) + 32'd4));

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_stall_on_traffic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  assert_inval_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && (cpu_op == 3'd4 || cpu_op == 3'd7)) |-> !(mem_req && mem_we));
endmodule

bind dcache_wb dcache_wb_chk #(.LINES(CACHE_KB * 32)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr)
);

// File: tb/tb_dcache_wb.sv
module tb_dcache_wb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [2:0]  cpu_op = 3'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  dcache_wb dut (.*);

  // memory model
  bit [31:0] mem [4096];
  bit        wr  [4096];
  int        cyc = 0, ev_total = 0;
  bit        ev_we   [64];
  bit [31:0] ev_addr [64];
  bit        p0v = 0, p1v = 0;
  bit [31:0] p0d = '0, p1d = '0;

  function automatic bit [31:0] iv(input bit [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction
  function automatic bit [31:0] peek(input bit [31:0] a);
    return wr[a[13:2]] ? mem[a[13:2]] : iv(a);
  endfunction

  assign mem_gnt    = (cyc % 3) != 2;
  assign mem_rvalid = p1v;
  assign mem_rdata  = p1d;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p1v <= p0v;
    p1d <= p0d;
    p0v <= 1'b0;
    if (mem_req && mem_gnt) begin
      ev_we[ev_total % 64]   <= mem_we;
      ev_addr[ev_total % 64] <= mem_addr;
      ev_total <= ev_total + 1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr[mem_addr[13:2]]  <= 1'b1;
      end else begin
        p0v <= 1'b1;
        p0d <= peek(mem_addr);
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit [2:0] op, input bit [31:0] addr, input bit [31:0] wd,
                        input bit [3:0] be, output bit [31:0] rd, output int waits,
                        output int start);
    @(negedge clk);
    start = ev_total;
    cpu_req = 1'b1; cpu_op = op; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
    #1;
    waits = 0;
    while (!cpu_ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic traffic(input int start, input int nw, input bit [31:0] wbase,
                         input int nr, input bit [31:0] rbase, input string req);
    bit ok = (ev_total - start) == nw + nr;
    bit [31:0] badA = '0, expA = '0;
    for (int k = 0; k < nw + nr && ok; k++) begin
      bit [31:0] e = (k < nw) ? wbase + 4 * k : rbase + 4 * (k - nw);
      if (ev_we[(start + k) % 64] != (k < nw) || ev_addr[(start + k) % 64] != e) begin
        ok = 1'b0; badA = ev_addr[(start + k) % 64]; expA = e;
      end
    end
    check(ok, req, $sformatf("traffic (%0d events, want %0dW+%0dR)", ev_total - start, nw, nr),
          badA, expA);
  endtask

  bit [31:0] rd;
  int waits, st;

  function automatic bit [31:0] mrg(input bit [31:0] o, input bit [31:0] n, input bit [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  task automatic t_reset_and_fill;
    bit quiet = 1'b1;
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 3'd0; cpu_addr = 32'h108;
    @(negedge clk) rst_n = 1'b1;
    st = ev_total;
    for (int i = 0; i < 20; i++) begin
      #1 if (cpu_ready || mem_req) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R1", "ready/mem_req during sweep", {30'd0, cpu_ready, mem_req}, 32'd0);
    waits = 20;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; waits++; end
    rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_req = 1'b0;
    check(waits >= 32, "R1", "cycles before first completion", waits, 32);
    traffic(st, 0, 0, 8, 32'h100, "R4");
    check(rd == iv(32'h108), "R4", "fill read data", rd, iv(32'h108));
  endtask

  task automatic t_hits;
    access(3'd0, 32'h114, 0, 0, rd, waits, st);
    check(waits == 0, "R2", "read hit wait", waits, 0);
    check(rd == iv(32'h114), "R2", "read hit data", rd, iv(32'h114));
    traffic(st, 0, 0, 0, 0, "R2");
    access(3'd1, 32'h108, 32'hDEADBEEF, 4'b0101, rd, waits, st);
    check(waits == 0, "R3", "write hit wait", waits, 0);
    traffic(st, 0, 0, 0, 0, "R3");
    access(3'd0, 32'h108, 0, 0, rd, waits, st);
    check(rd == mrg(iv(32'h108), 32'hDEADBEEF, 4'b0101), "R3", "byte merge", rd,
          mrg(iv(32'h108), 32'hDEADBEEF, 4'b0101));
  endtask

  task automatic t_evict;
    access(3'd0, 32'h500, 0, 0, rd, waits, st);
    traffic(st, 8, 32'h100, 8, 32'h500, "R5");
    check(peek(32'h108) == mrg(iv(32'h108), 32'hDEADBEEF, 4'b0101), "R5", "victim data in memory",
          peek(32'h108), mrg(iv(32'h108), 32'hDEADBEEF, 4'b0101));
    check(rd == iv(32'h500), "R5", "new line data", rd, iv(32'h500));
  endtask

  task automatic t_store_miss;
    access(3'd1, 32'h240, 32'h12345678, 4'hF, rd, waits, st);
    traffic(st, 0, 0, 8, 32'h240, "R6");
    access(3'd0, 32'h240, 0, 0, rd, waits, st);
    check(rd == 32'h12345678, "R6", "merged store", rd, 32'h12345678);
    access(3'd0, 32'h244, 0, 0, rd, waits, st);
    check(rd == iv(32'h244), "R6", "neighbour word", rd, iv(32'h244));
    check(peek(32'h240) == iv(32'h240), "R6", "memory untouched", peek(32'h240), iv(32'h240));
  endtask

  task automatic t_clean_addr;
    access(3'd2, 32'h240, 0, 0, rd, waits, st);
    traffic(st, 8, 32'h240, 0, 0, "R7");
    check(peek(32'h240) == 32'h12345678, "R7", "cleaned word", peek(32'h240), 32'h12345678);
    access(3'd0, 32'h240, 0, 0, rd, waits, st);
    check(waits == 0 && ev_total == st, "R7", "still valid after clean", waits, 0);
    access(3'd0, 32'h640, 0, 0, rd, waits, st);
    traffic(st, 0, 0, 8, 32'h640, "R7");
  endtask

  task automatic t_addr_miss_noop;
    access(3'd1, 32'h640, 32'hCAFEF00D, 4'hF, rd, waits, st);
    for (int op = 2; op <= 4; op++) begin
      access(3'(op), 32'h240, 0, 0, rd, waits, st);
      check(waits == 0, "R10", $sformatf("op %0d miss wait", op), waits, 0);
      traffic(st, 0, 0, 0, 0, "R10");
    end
    access(3'd0, 32'h640, 0, 0, rd, waits, st);
    check(rd == 32'hCAFEF00D && waits == 0, "R10", "line unchanged", rd, 32'hCAFEF00D);
  endtask

  task automatic t_flush_inval_addr;
    access(3'd3, 32'h640, 0, 0, rd, waits, st);
    traffic(st, 8, 32'h640, 0, 0, "R8");
    access(3'd0, 32'h640, 0, 0, rd, waits, st);
    traffic(st, 0, 0, 8, 32'h640, "R8");
    check(rd == 32'hCAFEF00D, "R8", "refetched data", rd, 32'hCAFEF00D);
    access(3'd1, 32'h640, 32'h0BADC0DE, 4'hF, rd, waits, st);
    access(3'd4, 32'h640, 0, 0, rd, waits, st);
    traffic(st, 0, 0, 0, 0, "R9");
    access(3'd0, 32'h640, 0, 0, rd, waits, st);
    traffic(st, 0, 0, 8, 32'h640, "R9");
    check(rd == 32'hCAFEF00D, "R9", "store discarded", rd, 32'hCAFEF00D);
  endtask

  task automatic t_index_ops;
    access(3'd0, 32'h300, 0, 0, rd, waits, st);
    access(3'd1, 32'h300, 32'h11112222, 4'hF, rd, waits, st);
    access(3'd5, 32'hABCD0018, 0, 0, rd, waits, st);
    traffic(st, 8, 32'h300, 0, 0, "R11");
    check(peek(32'h300) == 32'h11112222, "R11", "clean by index data", peek(32'h300), 32'h11112222);
    access(3'd0, 32'h300, 0, 0, rd, waits, st);
    check(waits == 0 && ev_total == st, "R11", "valid after index clean", waits, 0);
    access(3'd6, 32'h18, 0, 0, rd, waits, st);
    check(waits == 0, "R11", "flush clean line wait", waits, 0);
    traffic(st, 0, 0, 0, 0, "R11");
    access(3'd0, 32'h300, 0, 0, rd, waits, st);
    traffic(st, 0, 0, 8, 32'h300, "R11");
    access(3'd1, 32'h300, 32'h33334444, 4'hF, rd, waits, st);
    access(3'd6, 32'hFFFFFC18, 0, 0, rd, waits, st);
    traffic(st, 8, 32'h300, 0, 0, "R11");
    access(3'd0, 32'h300, 0, 0, rd, waits, st);
    check(rd == 32'h33334444, "R11", "flush by index refetch", rd, 32'h33334444);
    access(3'd1, 32'h300, 32'h55556666, 4'hF, rd, waits, st);
    access(3'd7, 32'h00000018, 0, 0, rd, waits, st);
    traffic(st, 0, 0, 0, 0, "R9");
    access(3'd0, 32'h300, 0, 0, rd, waits, st);
    check(rd == 32'h33334444, "R11", "invalidate by index", rd, 32'h33334444);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_fill();
    t_hits();
    t_evict();
    t_store_miss();
    t_clean_addr();
    t_addr_miss_noop();
    t_flush_inval_addr();
    t_index_ops();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule